// File: doc/BRIEF.md
# Page-Offset-Indexed Data Cache with Overlapped Translation

This block is a 4 KB direct-mapped load cache that sits in front of memory and behind a processor load port. Its 1024 lines of one 32-bit word each are selected using only bits of the page offset: address bits 11:2 pick the line and bits 1:0 pick a byte in the word. Because those bits need no translation, the line array is read in the same cycle that a fully associative translation buffer looks up the virtual page number (address bits 31:12) together with the requester's process tag.

A load hits only when the translation hits and the 20-bit frame tag stored with the line equals the frame number the translation returns. Because the tag is a physical frame number, two virtual pages that map to the same frame share cached lines. When the translation hits but the line does not, the block fetches the word from memory at the physical address. It then writes the data with its frame tag and answers the load.

When the translation misses, the block raises a miss output that carries the page number and the process tag. It stalls until an external page walker writes an entry through the fill port, and then retries the lookup. Software-side invalidation is offered in two forms: one clears every translation, and the other clears only those of one process tag.

Top module: `vipt_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `xlat_miss` and `mem_req_valid` are 0. No translation is valid, so the first load raises a translation miss.
- R2: A load accepted while `req_ready` is 1 hits when its translation hits, the indexed line is valid and the line's frame tag equals the translated frame. `resp_valid` then rises on the following cycle with the cached word, and no memory request is made.
- R3: On a translation miss, `xlat_miss` rises the cycle after acceptance with `xlat_miss_vpn` = address bits 31:12 and `xlat_miss_pid` = the request's process tag. It stays high with stable outputs, and `req_ready` stays 0, until a fill arrives.
- R4: A fill writes a valid entry (page number, process tag, frame, rights), and a request stalled on a translation miss is retried after the fill.
- R5: On a translation hit with a line miss, `mem_req_valid` is held with a stable `mem_req_paddr` = {frame, address bits 11:2, 2'b00} until `mem_resp_valid`. The next cycle `resp_valid` returns the memory word, and the line keeps that word and frame tag for later hits.
- R6: The line tag is the physical frame: a second virtual page mapped to the same frame hits a line filled through the first. A different frame at the same line index misses and replaces the line.
- R7: Address bits 1:0 do not change the line selected. `resp_byte` is byte bits 1:0 of the returned word, where byte 0 is word bits 7:0.
- R8: Rights bit 0 grants reads. A load whose translation has bit 0 clear returns `resp_valid` with `resp_fault` = 1 and `resp_data` = 0, and makes no memory request.
- R9: A translation entry matches only a request carrying the same process tag.
- R10: A pulse on `flush_all` invalidates every translation entry.
- R11: A pulse on `flush_pid_valid` invalidates only the entries whose process tag equals `flush_pid`.
- R12: When a fill and a flush fall in the same cycle, the flush is applied first and the filled entry stays valid.
- R13: A fill whose page number and process tag match a valid entry replaces that entry's frame and rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_vaddr | input | 32 | Load virtual address |
| req_pid | input | 4 | Requester process tag |
| req_ready | output | 1 | Block can accept a load this cycle |
| resp_valid | output | 1 | Load answer valid (one cycle) |
| resp_data | output | 32 | Loaded word |
| resp_byte | output | 8 | Byte of the word chosen by address bits 1:0 |
| resp_fault | output | 1 | Load refused: no read right |
| xlat_miss | output | 1 | Translation missing, waiting for a fill |
| xlat_miss_vpn | output | 20 | Page number that missed |
| xlat_miss_pid | output | 4 | Process tag that missed |
| fill_valid | input | 1 | Write a translation entry |
| fill_vpn | input | 20 | Page number of the new entry |
| fill_pid | input | 4 | Process tag of the new entry |
| fill_pfn | input | 20 | Physical frame of the new entry |
| fill_rights | input | 2 | Rights of the new entry (bit 0 = read) |
| flush_all | input | 1 | Invalidate all translation entries |
| flush_pid_valid | input | 1 | Invalidate entries of one process tag |
| flush_pid | input | 4 | Process tag to invalidate |
| mem_req_valid | output | 1 | Line refill request to memory |
| mem_req_paddr | output | 32 | Physical word address of the refill |
| mem_resp_valid | input | 1 | Refill data valid |
| mem_resp_data | input | 32 | Refill data |

## Verification
A translation fill and a process-tag flush can land on the translation buffer in the same cycle, and the flush can name the very tag being filled. The bench drives both in one cycle, with the flush's tag equal to the fill's. It then judges the outcome at the ports: a load through the newly filled page must complete without a translation miss, and a load through an older page with that tag must raise one. The overlap of line read and translation is judged by loads that must answer on the first cycle after acceptance without a memory request, including a load through an aliased page.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int VA_W        = 32;
    localparam int PAGE_OFF_W  = 12;
    localparam int BYTE_SEL_W  = 2;
    localparam int IDX_W       = PAGE_OFF_W - BYTE_SEL_W;
    localparam int VPN_W       = VA_W - PAGE_OFF_W;
    localparam int PFN_W       = 20;
    localparam int PA_W        = PFN_W + PAGE_OFF_W;
    localparam int BYTE_BITS   = 8;
    localparam int WORD_W      = BYTE_BITS << BYTE_SEL_W;
    localparam int PID_W       = 4;
    localparam int RIGHTS_W    = 2;
    localparam int RIGHT_READ  = 0;

    typedef struct packed {
        logic                valid;
        logic [PID_W-1:0]    pid;
        logic [VPN_W-1:0]    vpn;
        logic [PFN_W-1:0]    pfn;
        logic [RIGHTS_W-1:0] rights;
    } xlat_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XMISS,
        ST_RETRY,
        ST_REFILL
    } ctl_state_t;

    typedef enum logic [1:0] {
        LR_HIT,
        LR_FAULT,
        LR_REFILL,
        LR_XMISS
    } look_result_t;

    function automatic logic [PA_W-1:0] make_paddr(
        input logic [PFN_W-1:0] pfn,
        input logic [IDX_W-1:0] idx
    );
        return {pfn, idx, {BYTE_SEL_W{1'b0}}};
    endfunction

    function automatic logic [BYTE_BITS-1:0] pick_byte(
        input logic [WORD_W-1:0]     word,
        input logic [BYTE_SEL_W-1:0] sel
    );
        return word[sel*BYTE_BITS +: BYTE_BITS];
    endfunction

endpackage

// File: rtl/vipt_xlat_buf.sv
module vipt_xlat_buf
    import vipt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [VPN_W-1:0]    look_vpn,
    input  logic [PID_W-1:0]    look_pid,
    output logic                hit,
    output logic [PFN_W-1:0]    hit_pfn,
    output logic [RIGHTS_W-1:0] hit_rights,
    input  logic                fill_valid,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PID_W-1:0]    fill_pid,
    input  logic [PFN_W-1:0]    fill_pfn,
    input  logic [RIGHTS_W-1:0] fill_rights,
    input  logic                flush_all,
    input  logic                flush_pid_valid,
    input  logic [PID_W-1:0]    flush_pid
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    xlat_entry_t        tbl [DEPTH];
    logic [DEPTH-1:0]   match_vec;
    logic [DEPTH-1:0]   same_vec;
    logic [DEPTH-1:0]   free_vec;
    logic [PTR_W-1:0]   rr_ptr;
    logic [PTR_W-1:0]   same_idx;
    logic [PTR_W-1:0]   free_idx;
    logic [PTR_W-1:0]   victim;
    logic               found_same;
    logic               found_free;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match_vec[g] = tbl[g].valid && (tbl[g].vpn == look_vpn)
                              && (tbl[g].pid == look_pid);
        assign same_vec[g]  = tbl[g].valid && (tbl[g].vpn == fill_vpn)
                              && (tbl[g].pid == fill_pid);
        assign free_vec[g]  = !tbl[g].valid;
    end

    always_comb begin
        hit        = |match_vec;
        hit_pfn    = '0;
        hit_rights = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_vec[i]) begin
                hit_pfn    = hit_pfn    | tbl[i].pfn;
                hit_rights = hit_rights | tbl[i].rights;
            end
        end
    end

    always_comb begin
        found_same = 1'b0;
        found_free = 1'b0;
        same_idx   = '0;
        free_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (same_vec[i] && !found_same) begin
                found_same = 1'b1;
                same_idx   = PTR_W'(i);
            end
            if (free_vec[i] && !found_free) begin
                found_free = 1'b1;
                free_idx   = PTR_W'(i);
            end
        end
        if (found_same)      victim = same_idx;
        else if (found_free) victim = free_idx;
        else                 victim = rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
            rr_ptr <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (flush_all || (flush_pid_valid && tbl[i].pid == flush_pid))
                    tbl[i].valid <= 1'b0;
            end
            if (fill_valid) begin
                tbl[victim] <= '{valid: 1'b1, pid: fill_pid, vpn: fill_vpn,
                                 pfn: fill_pfn, rights: fill_rights};
                if (!found_same && !found_free)
                    rr_ptr <= (rr_ptr == PTR_W'(DEPTH - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store
    import vipt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [PFN_W-1:0]  rd_tag,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PFN_W-1:0]  wr_tag,
    input  logic [WORD_W-1:0] wr_data
);

    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  line_vld;
    logic [PFN_W-1:0]  tag_mem  [LINES];
    logic [WORD_W-1:0] data_mem [LINES];

    assign rd_valid = line_vld[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_data  = data_mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            line_vld <= '0;
        end else if (wr_en) begin
            line_vld[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int TLB_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [PID_W-1:0]     req_pid,
    output logic                 req_ready,
    output logic                 resp_valid,
    output logic [WORD_W-1:0]    resp_data,
    output logic [BYTE_BITS-1:0] resp_byte,
    output logic                 resp_fault,
    output logic                 xlat_miss,
    output logic [VPN_W-1:0]     xlat_miss_vpn,
    output logic [PID_W-1:0]     xlat_miss_pid,
    input  logic                 fill_valid,
    input  logic [VPN_W-1:0]     fill_vpn,
    input  logic [PID_W-1:0]     fill_pid,
    input  logic [PFN_W-1:0]     fill_pfn,
    input  logic [RIGHTS_W-1:0]  fill_rights,
    input  logic                 flush_all,
    input  logic                 flush_pid_valid,
    input  logic [PID_W-1:0]     flush_pid,
    output logic                 mem_req_valid,
    output logic [PA_W-1:0]      mem_req_paddr,
    input  logic                 mem_resp_valid,
    input  logic [WORD_W-1:0]    mem_resp_data
);

    ctl_state_t              state;
    look_result_t            outcome;
    logic [VA_W-1:0]         held_vaddr;
    logic [PID_W-1:0]        held_pid;
    logic [PFN_W-1:0]        held_pfn;

    logic [VA_W-1:0]         look_vaddr;
    logic [PID_W-1:0]        look_pid;
    logic                    look_active;
    logic [IDX_W-1:0]        look_idx;
    logic [VPN_W-1:0]        look_vpn;
    logic [BYTE_SEL_W-1:0]   look_bsel;
    logic [IDX_W-1:0]        held_idx;

    logic                    tlb_hit;
    logic [PFN_W-1:0]        tlb_pfn;
    logic [RIGHTS_W-1:0]     tlb_rights;
    logic                    line_valid;
    logic [PFN_W-1:0]        line_tag;
    logic [WORD_W-1:0]       line_data;
    logic                    line_wr;

    assign look_vaddr  = (state == ST_IDLE) ? req_vaddr : held_vaddr;
    assign look_pid    = (state == ST_IDLE) ? req_pid   : held_pid;
    assign look_active = ((state == ST_IDLE) && req_valid) || (state == ST_RETRY);
    assign look_vpn    = look_vaddr[VA_W-1:PAGE_OFF_W];
    assign look_idx    = look_vaddr[PAGE_OFF_W-1:BYTE_SEL_W];
    assign look_bsel   = look_vaddr[BYTE_SEL_W-1:0];
    assign held_idx    = held_vaddr[PAGE_OFF_W-1:BYTE_SEL_W];

    vipt_xlat_buf #(.DEPTH(TLB_DEPTH)) u_xlat (
        .clk            (clk),
        .rst            (rst),
        .look_vpn       (look_vpn),
        .look_pid       (look_pid),
        .hit            (tlb_hit),
        .hit_pfn        (tlb_pfn),
        .hit_rights     (tlb_rights),
        .fill_valid     (fill_valid),
        .fill_vpn       (fill_vpn),
        .fill_pid       (fill_pid),
        .fill_pfn       (fill_pfn),
        .fill_rights    (fill_rights),
        .flush_all      (flush_all),
        .flush_pid_valid(flush_pid_valid),
        .flush_pid      (flush_pid)
    );

    assign line_wr = (state == ST_REFILL) && mem_resp_valid;

    vipt_line_store u_lines (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (look_idx),
        .rd_valid(line_valid),
        .rd_tag  (line_tag),
        .rd_data (line_data),
        .wr_en   (line_wr),
        .wr_idx  (held_idx),
        .wr_tag  (held_pfn),
        .wr_data (mem_resp_data)
    );

    always_comb begin
        if (!tlb_hit)                         outcome = LR_XMISS;
        else if (!tlb_rights[RIGHT_READ])     outcome = LR_FAULT;
        else if (line_valid && line_tag == tlb_pfn) outcome = LR_HIT;
        else                                  outcome = LR_REFILL;
    end

    assign req_ready     = (state == ST_IDLE);
    assign xlat_miss     = (state == ST_XMISS);
    assign xlat_miss_vpn = held_vaddr[VA_W-1:PAGE_OFF_W];
    assign xlat_miss_pid = held_pid;
    assign mem_req_valid = (state == ST_REFILL);
    assign mem_req_paddr = make_paddr(held_pfn, held_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            held_vaddr <= '0;
            held_pid   <= '0;
            held_pfn   <= '0;
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            resp_data  <= '0;
            resp_byte  <= '0;
        end else begin
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            if ((state == ST_IDLE) && req_valid) begin
                held_vaddr <= req_vaddr;
                held_pid   <= req_pid;
            end
            if (look_active) begin
                case (outcome)
                    LR_HIT: begin
                        resp_valid <= 1'b1;
                        resp_data  <= line_data;
                        resp_byte  <= pick_byte(line_data, look_bsel);
                        state      <= ST_IDLE;
                    end
                    LR_FAULT: begin
                        resp_valid <= 1'b1;
                        resp_fault <= 1'b1;
                        resp_data  <= '0;
                        resp_byte  <= '0;
                        state      <= ST_IDLE;
                    end
                    LR_REFILL: begin
                        held_pfn <= tlb_pfn;
                        state    <= ST_REFILL;
                    end
                    default: state <= ST_XMISS;
                endcase
            end else begin
                case (state)
                    ST_XMISS: if (fill_valid) state <= ST_RETRY;
                    ST_REFILL: begin
                        if (mem_resp_valid) begin
                            resp_valid <= 1'b1;
                            resp_data  <= mem_resp_data;
                            resp_byte  <= pick_byte(mem_resp_data,
                                                    held_vaddr[BYTE_SEL_W-1:0]);
                            state      <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/vipt_cache_checker.sv
module vipt_cache_checker
    import vipt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_fault,
    input logic [WORD_W-1:0] resp_data,
    input logic              xlat_miss,
    input logic [VPN_W-1:0]  xlat_miss_vpn,
    input logic              fill_valid,
    input logic              mem_req_valid,
    input logic [PA_W-1:0]   mem_req_paddr,
    input logic              mem_resp_valid
);

    assert_miss_stalls_R3: assert property (@(posedge clk) disable iff (rst)
        xlat_miss |-> (!req_ready && !mem_req_valid));

    assert_miss_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (xlat_miss && !fill_valid) |=> (xlat_miss && $stable(xlat_miss_vpn)));

    assert_refill_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_resp_valid) |=> (mem_req_valid && $stable(mem_req_paddr)));

    assert_refill_stalls_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    assert_refill_answers_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_resp_valid) |=> (resp_valid && !mem_req_valid));

    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (rst)
        resp_fault |-> (resp_valid && resp_data == '0));

endmodule

bind vipt_cache vipt_cache_checker u_checker (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_fault    (resp_fault),
    .resp_data     (resp_data),
    .xlat_miss     (xlat_miss),
    .xlat_miss_vpn (xlat_miss_vpn),
    .fill_valid    (fill_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_paddr (mem_req_paddr),
    .mem_resp_valid(mem_resp_valid)
);

// File: tb/vipt_cache_bench.sv
`timescale 1ns/1ps
module vipt_cache_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [3:0]  req_pid = '0;
    logic        req_ready;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic [7:0]  resp_byte;
    logic        resp_fault;
    logic        xlat_miss;
    logic [19:0] xlat_miss_vpn;
    logic [3:0]  xlat_miss_pid;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [3:0]  fill_pid = '0;
    logic [19:0] fill_pfn = '0;
    logic [1:0]  fill_rights = '0;
    logic        flush_all = 1'b0;
    logic        flush_pid_valid = 1'b0;
    logic [3:0]  flush_pid = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_paddr;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;

    int checks = 0;
    int failures = 0;

    // outcome of the last wait
    logic        o_resp, o_miss, o_fault;
    logic [31:0] o_data, o_paddr;
    logic [7:0]  o_byte;
    int          o_lat, o_mem;

    always #2.5 clk = ~clk;

    vipt_cache u_vipt_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_pid(req_pid),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_byte(resp_byte), .resp_fault(resp_fault),
        .xlat_miss(xlat_miss), .xlat_miss_vpn(xlat_miss_vpn), .xlat_miss_pid(xlat_miss_pid),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_pfn(fill_pfn), .fill_rights(fill_rights),
        .flush_all(flush_all), .flush_pid_valid(flush_pid_valid), .flush_pid(flush_pid),
        .mem_req_valid(mem_req_valid), .mem_req_paddr(mem_req_paddr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] pa);
        return pa ^ 32'h5A00_00C3;
    endfunction

    function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] s);
        return 8'((w >> (8 * s)) & 32'hFF);
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Waits at falling edges for a response or a translation miss,
    // serving memory refills along the way.
    task automatic wait_outcome();
        o_resp = 0; o_miss = 0; o_fault = 0; o_data = '0; o_byte = '0;
        o_lat = 0; o_mem = 0; o_paddr = '0;
        for (int i = 0; i < 40; i++) begin
            mem_resp_valid = 1'b0;
            if (resp_valid) begin
                o_resp = 1; o_data = resp_data; o_byte = resp_byte;
                o_fault = resp_fault; o_lat = i;
                break;
            end
            if (xlat_miss) begin
                o_miss = 1; o_lat = i;
                break;
            end
            if (mem_req_valid) begin
                mem_resp_valid = 1'b1;
                mem_resp_data  = mem_word(mem_req_paddr);
                o_paddr = mem_req_paddr;
                o_mem++;
            end
            @(negedge clk);
        end
        mem_resp_valid = 1'b0;
    endtask

    task automatic load(input logic [31:0] va, input logic [3:0] pid);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_pid = pid;
        @(negedge clk);
        req_valid = 1'b0;
        wait_outcome();
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [3:0] pid,
                        input logic [19:0] pfn, input logic [1:0] rights);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pid = pid;
        fill_pfn = pfn; fill_rights = rights;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic resolve(input logic [19:0] vpn, input logic [3:0] pid,
                           input logic [19:0] pfn);
        fill(vpn, pid, pfn, 2'b01);
        wait_outcome();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
        check(!resp_valid && !xlat_miss && !mem_req_valid, "R1 idle outputs",
              {29'd0, resp_valid, xlat_miss, mem_req_valid}, 0);
        load(32'h0001_2344, 4'd1);
        check(o_miss == 1'b1, "R1 first load misses translation", 32'(o_miss), 1);
        check(xlat_miss_vpn == 20'h00012 && xlat_miss_pid == 4'd1, "R3 miss vpn/pid",
              {8'd0, xlat_miss_pid, xlat_miss_vpn}, {8'd0, 4'd1, 20'h00012});
        repeat (3) @(negedge clk);
        check(xlat_miss && !req_ready, "R3 stall held", {30'd0, xlat_miss, req_ready}, 2);
        resolve(20'h00012, 4'd1, 20'hABCDE);
        check(o_resp && o_mem == 1, "R4 retry after fill", 32'(o_mem), 1);
        check(o_paddr == 32'hABCDE344, "R5 refill paddr", o_paddr, 32'hABCDE344);
        check(o_data == mem_word(32'hABCDE344), "R5 refill data", o_data,
              mem_word(32'hABCDE344));
        check(o_byte == byte_of(mem_word(32'hABCDE344), 2'd0), "R7 byte 0",
              32'(o_byte), 32'(byte_of(mem_word(32'hABCDE344), 2'd0)));
    endtask

    task automatic t_hit();
        load(32'h0001_2346, 4'd1);
        check(o_resp && o_lat == 0 && o_mem == 0, "R2 hit next cycle no memory",
              32'(o_lat + 16 * o_mem), 0);
        check(o_data == mem_word(32'hABCDE344), "R2 hit data", o_data,
              mem_word(32'hABCDE344));
        check(o_byte == byte_of(mem_word(32'hABCDE344), 2'd2), "R7 byte 2",
              32'(o_byte), 32'(byte_of(mem_word(32'hABCDE344), 2'd2)));
    endtask

    task automatic t_alias();
        fill(20'h00077, 4'd1, 20'hABCDE, 2'b01);
        load(32'h0007_7347, 4'd1);
        check(o_resp && o_lat == 0 && o_mem == 0, "R6 alias hits shared line",
              32'(o_mem), 0);
        check(o_byte == byte_of(mem_word(32'hABCDE344), 2'd3), "R7 byte 3 alias",
              32'(o_byte), 32'(byte_of(mem_word(32'hABCDE344), 2'd3)));
    endtask

    task automatic t_conflict();
        fill(20'h00055, 4'd1, 20'h11111, 2'b01);
        load(32'h0005_5344, 4'd1);
        check(o_mem == 1 && o_paddr == 32'h11111344, "R6 other frame misses",
              o_paddr, 32'h11111344);
        load(32'h0001_2344, 4'd1);
        check(o_mem == 1 && o_paddr == 32'hABCDE344, "R6 line replaced",
              o_paddr, 32'hABCDE344);
    endtask

    task automatic t_fault();
        fill(20'h00099, 4'd1, 20'h22222, 2'b10);
        load(32'h0009_9010, 4'd1);
        check(o_resp && o_fault && o_mem == 0, "R8 fault no memory",
              {30'd0, o_fault, o_resp}, 3);
        check(o_data == 32'd0, "R8 fault data zero", o_data, 0);
    endtask

    task automatic t_pid();
        load(32'h0001_2344, 4'd2);
        check(o_miss == 1'b1, "R9 other tag misses", 32'(o_miss), 1);
        resolve(20'h00012, 4'd2, 20'h33333);
        check(o_paddr == 32'h33333344, "R9 tag-2 frame", o_paddr, 32'h33333344);
        load(32'h0001_2344, 4'd1);
        check(!o_miss && o_paddr == 32'hABCDE344, "R9 tag-1 frame kept",
              o_paddr, 32'hABCDE344);
    endtask

    task automatic t_flush_pid();
        @(negedge clk);
        flush_pid_valid = 1'b1; flush_pid = 4'd2;
        @(negedge clk);
        flush_pid_valid = 1'b0;
        load(32'h0001_2344, 4'd2);
        check(o_miss == 1'b1, "R11 flushed tag misses", 32'(o_miss), 1);
        resolve(20'h00012, 4'd2, 20'h33333);
        load(32'h0007_7344, 4'd1);
        check(!o_miss && o_resp, "R11 other tag survives", 32'(o_miss), 0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        flush_pid_valid = 1'b1; flush_pid = 4'd1;
        fill_valid = 1'b1; fill_vpn = 20'h00044; fill_pid = 4'd1;
        fill_pfn = 20'h44444; fill_rights = 2'b01;
        @(negedge clk);
        flush_pid_valid = 1'b0; fill_valid = 1'b0;
        load(32'h0004_4000, 4'd1);
        check(!o_miss && o_paddr == 32'h44444000, "R12 fill survives flush",
              o_paddr, 32'h44444000);
        load(32'h0001_2344, 4'd1);
        check(o_miss == 1'b1, "R12 flush applied", 32'(o_miss), 1);
        resolve(20'h00012, 4'd1, 20'hABCDE);
    endtask

    task automatic t_overwrite();
        fill(20'h00012, 4'd1, 20'h66666, 2'b01);
        load(32'h0001_2344, 4'd1);
        check(!o_miss && o_mem == 1 && o_paddr == 32'h66666344, "R13 entry replaced",
              o_paddr, 32'h66666344);
    endtask

    task automatic t_flush_all();
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        load(32'h0004_4000, 4'd1);
        check(o_miss == 1'b1, "R10 tag-1 entry gone", 32'(o_miss), 1);
        resolve(20'h00044, 4'd1, 20'h44444);
        load(32'h0001_2344, 4'd2);
        check(o_miss == 1'b1, "R10 tag-2 entry gone", 32'(o_miss), 1);
        resolve(20'h00012, 4'd2, 20'h33333);
        check(o_resp == 1'b1, "R10 refill after flush", 32'(o_resp), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary_and_end();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hit();
        t_alias();
        t_conflict();
        t_fault();
        t_pid();
        t_flush_pid();
        t_same_cycle();
        t_overwrite();
        t_flush_all();
        repeat (3) @(negedge clk);
        summary_and_end();
    end

endmodule